// File: doc/BRIEF.md
# I/O Window and Interrupt Number Allocator

This block runs once per start pulse and walks a fixed table of devices. For every device it turns on I/O and memory decode, gives each unplaced I/O base register a base address from a bump pointer that runs through a 64 KiB I/O window, and gives an interrupt number to each device that asks for one. All table traffic passes through one indexed port. The block drives a device index and a base-register index. The table answers combinationally. The block then returns write strobes in that same cycle. Each table access costs one clock.

Interrupt numbers come from one of two schemes, picked by a strap input. In the advanced scheme, the number is derived from the device number in the identifier. In the legacy scheme, a counter steps round-robin through a fixed pool of five lines, and every line handed out is recorded in a used-line mask. When the walk finishes, the block gives a one-cycle done pulse. It then holds the used-line mask and the per-device error flags until the next start.

Top module: `io_irq_assigner`

## Requirements
- R1: A start pulse seen while idle begins a walk of NDEV*(NBAR+2) cycles with busy high. The cycle after the walk has done high for exactly one cycle, with busy low. A start pulse during a walk is ignored.
- R2: Each device, in index order, gets exactly one cmd_we strobe, which means set command bits 1:0 (I/O and memory decode enable). Its base registers are visited in order next, then its interrupt slot. At most one write strobe is high per cycle.
- R3: A base register whose length is 0 or whose current address is nonzero is skipped. It gets no write and raises no error.
- R4: An unplaced base register with bar_mem=1 (memory type) is not placed and sets dev_err for that device.
- R5: The I/O pointer starts at 0x1000 on every start. A placed I/O register gets bar_wdata equal to the pointer, and the pointer then advances by its length.
- R6: If pointer plus length is 0x10000 or more, the register is not placed, dev_err for that device is set, and the pointer does not move.
- R7: Only a device whose dev_irq is 0 gets an irq_we strobe. Any other value, including 0xFF (no interrupt wanted), is left untouched.
- R8: With irq_mode_adv=1, the assigned number is 16 + (dev_id[15:11] mod 4), and used_irqs is not changed.
- R9: With irq_mode_adv=0, a counter cleared to 0 at start advances modulo 16 until it reaches a line in the pool {5,7,9,10,11}. That line is assigned and its bit is set in used_irqs, so the order is 5,7,9,10,11,5,... used_irqs and dev_err are cleared at start and held after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one walk of the table |
| irq_mode_adv | input | 1 | 1: device-number interrupt mapping; 0: legacy pool |
| tbl_dev | output | DW | Device index presented to the table |
| tbl_bar | output | BW | Base-register index presented to the table |
| dev_id | input | 16 | Identifier of device tbl_dev (bits 15:11 device number) |
| dev_irq | input | 8 | Current interrupt number of device tbl_dev |
| bar_mem | input | 1 | Register tbl_bar of tbl_dev is memory type |
| bar_len | input | AW | Length of that register |
| bar_addr | input | AW | Current address of that register |
| cmd_we | output | 1 | Set decode enables (command bits 1:0) of tbl_dev |
| bar_we | output | 1 | Write bar_wdata to register tbl_bar of tbl_dev |
| bar_wdata | output | AW | Assigned I/O base |
| irq_we | output | 1 | Write irq_wdata as interrupt number of tbl_dev |
| irq_wdata | output | 8 | Assigned interrupt number |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse after the last device |
| used_irqs | output | 16 | Legacy lines handed out in the last walk |
| dev_err | output | NDEV | Per-device placement error flags |

## Verification
The bench goes after the window edge, where a sum of exactly 0x10000 must be refused. A design with an off-by-one compare would place that register and shift every later base. A placement that follows a refusal catches a pointer that moves on failure, because every later address would then be wrong. Running the legacy mode twice, with six requesting devices, checks both the 11-to-5 wrap and the counter clear at start. A counter that carries over between runs, or that misses the wrap, would give the wrong sequence. A start pulse in mid-walk and a device holding 0xFF check that neither one produces extra strobes.

// File: rtl/ioirq_pkg.sv
package ioirq_pkg;
    typedef enum logic [2:0] {S_IDLE, S_DEV, S_BAR, S_IRQ, S_DONE} walk_st_e;
    typedef enum logic [1:0] {BA_SKIP, BA_PLACE, BA_FAIL} bar_act_e;
    localparam logic [15:0] LEGACY_POOL = 16'h0EA0;
endpackage

// File: rtl/bar_eval.sv
module bar_eval
    import ioirq_pkg::*;
#(
    parameter int AW      = 32,
    parameter int WIN_TOP = 32'h10000
) (
    input  logic          is_mem,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ptr,
    output bar_act_e      act,
    output logic [AW-1:0] ptr_next
);
    localparam logic [AW:0] LIMIT = (AW+1)'(WIN_TOP);
    logic [AW:0] sum;

    always_comb begin
        sum      = {1'b0, ptr} + {1'b0, len};
        act      = BA_SKIP;
        ptr_next = ptr;
        if (len == '0 || addr != '0) begin
            act = BA_SKIP;
        end else if (is_mem) begin
            act = BA_FAIL;
        end else if (sum >= LIMIT) begin
            act = BA_FAIL;
        end else begin
            act      = BA_PLACE;
            ptr_next = sum[AW-1:0];
        end
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import ioirq_pkg::*;
(
    input  logic       adv,
    input  logic [4:0] dev_num,
    input  logic [3:0] cnt,
    output logic [7:0] irq,
    output logic [3:0] cnt_next
);
    logic [3:0] pick;
    logic       found;

    always_comb begin
        pick  = cnt;
        found = 1'b0;
        for (int k = 1; k <= 16; k++) begin
            logic [3:0] idx;
            idx = cnt + 4'(k);
            if (!found && LEGACY_POOL[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
        if (adv) begin
            irq      = 8'd16 + {6'd0, dev_num[1:0]};
            cnt_next = cnt;
        end else begin
            irq      = {4'd0, pick};
            cnt_next = pick;
        end
    end
endmodule

// File: rtl/io_irq_assigner.sv
module io_irq_assigner
    import ioirq_pkg::*;
#(
    parameter int NDEV    = 6,
    parameter int NBAR    = 2,
    parameter int AW      = 32,
    parameter int IO_BASE = 32'h1000,
    parameter int WIN_TOP = 32'h10000,
    localparam int DW     = (NDEV > 1) ? $clog2(NDEV) : 1,
    localparam int BW     = (NBAR > 1) ? $clog2(NBAR) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            irq_mode_adv,
    output logic [DW-1:0]   tbl_dev,
    output logic [BW-1:0]   tbl_bar,
    input  logic [15:0]     dev_id,
    input  logic [7:0]      dev_irq,
    input  logic            bar_mem,
    input  logic [AW-1:0]   bar_len,
    input  logic [AW-1:0]   bar_addr,
    output logic            cmd_we,
    output logic            bar_we,
    output logic [AW-1:0]   bar_wdata,
    output logic            irq_we,
    output logic [7:0]      irq_wdata,
    output logic            busy,
    output logic            done,
    output logic [15:0]     used_irqs,
    output logic [NDEV-1:0] dev_err
);
    localparam logic [DW-1:0] LAST_DEV = DW'(NDEV - 1);
    localparam logic [BW-1:0] LAST_BAR = BW'(NBAR - 1);

    typedef struct packed {
        walk_st_e        st;
        logic [DW-1:0]   dev;
        logic [BW-1:0]   bar;
        logic [AW-1:0]   ptr;
        logic [3:0]      cnt;
        logic [15:0]     used;
        logic [NDEV-1:0] err;
    } walk_t;

    walk_t w_d, w_q;
    bar_act_e      act;
    logic [AW-1:0] ptr_adv;
    logic [7:0]    irq_sel;
    logic [3:0]    cnt_adv;

    bar_eval #(.AW(AW), .WIN_TOP(WIN_TOP)) u_bar (
        .is_mem(bar_mem), .len(bar_len), .addr(bar_addr),
        .ptr(w_q.ptr), .act(act), .ptr_next(ptr_adv)
    );

    irq_pick u_irq (
        .adv(irq_mode_adv), .dev_num(dev_id[15:11]), .cnt(w_q.cnt),
        .irq(irq_sel), .cnt_next(cnt_adv)
    );

    always_comb begin
        w_d       = w_q;
        cmd_we    = 1'b0;
        bar_we    = 1'b0;
        bar_wdata = w_q.ptr;
        irq_we    = 1'b0;
        irq_wdata = irq_sel;
        case (w_q.st)
            S_IDLE: begin
                if (start) begin
                    w_d.st   = S_DEV;
                    w_d.dev  = '0;
                    w_d.bar  = '0;
                    w_d.ptr  = AW'(IO_BASE);
                    w_d.cnt  = '0;
                    w_d.used = '0;
                    w_d.err  = '0;
                end
            end
            S_DEV: begin
                cmd_we  = 1'b1;
                w_d.bar = '0;
                w_d.st  = S_BAR;
            end
            S_BAR: begin
                if (act == BA_PLACE) begin
                    bar_we  = 1'b1;
                    w_d.ptr = ptr_adv;
                end else if (act == BA_FAIL) begin
                    w_d.err[w_q.dev] = 1'b1;
                end
                if (w_q.bar == LAST_BAR) w_d.st = S_IRQ;
                else                     w_d.bar = w_q.bar + 1'b1;
            end
            S_IRQ: begin
                if (dev_irq == 8'd0) begin
                    irq_we  = 1'b1;
                    w_d.cnt = cnt_adv;
                    if (!irq_mode_adv) w_d.used[irq_sel[3:0]] = 1'b1;
                end
                if (w_q.dev == LAST_DEV) begin
                    w_d.st = S_DONE;
                end else begin
                    w_d.dev = w_q.dev + 1'b1;
                    w_d.st  = S_DEV;
                end
            end
            S_DONE:  w_d.st = S_IDLE;
            default: w_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{st: S_IDLE, dev: '0, bar: '0, ptr: AW'(IO_BASE),
                     cnt: '0, used: '0, err: '0};
        end else begin
            w_q <= w_d;
        end
    end

    assign tbl_dev   = w_q.dev;
    assign tbl_bar   = w_q.bar;
    assign busy      = (w_q.st != S_IDLE) && (w_q.st != S_DONE);
    assign done      = (w_q.st == S_DONE);
    assign used_irqs = w_q.used;
    assign dev_err   = w_q.err;

    // R2: one table write per cycle
    p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_we, bar_we, irq_we}));
    // R1: done lasts a single cycle
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3/R4: only unplaced I/O registers of nonzero length are written
    p_write_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bar_we |-> (bar_len != '0) && (bar_addr == '0) && !bar_mem);
    // R6: a placed register ends inside the window
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bar_we |-> (({1'b0, bar_wdata} + {1'b0, bar_len}) < (AW+1)'(WIN_TOP))
                   && (bar_wdata >= AW'(IO_BASE)));
    // R5: the pointer never moves backwards during a walk
    p_ptr_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && w_d.st != S_IDLE) |=> w_q.ptr >= $past(w_q.ptr));
    // R7: only requesting devices are written
    p_irq_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_we |-> dev_irq == 8'd0);
    // R8: advanced numbers stay in 16..19
    p_adv_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_we && irq_mode_adv) |-> (irq_wdata >= 8'd16) && (irq_wdata <= 8'd19));
    // R9: legacy numbers come from the pool
    p_legacy_pool_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_we && !irq_mode_adv) |-> (irq_wdata < 8'd16) && LEGACY_POOL[irq_wdata[3:0]]);
endmodule

// File: tb/sim_io_irq_assigner.sv
module sim_io_irq_assigner;
    localparam int CLK_PERIOD = 10;
    localparam int NDEV = 6;
    localparam int NBAR = 2;
    localparam int AW   = 32;
    localparam int DW   = $clog2(NDEV);
    localparam int BW   = 1;
    localparam int WALK = NDEV * (NBAR + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic irq_mode_adv = 1'b0;
    logic [DW-1:0] tbl_dev;
    logic [BW-1:0] tbl_bar;
    logic [15:0] dev_id;
    logic [7:0] dev_irq;
    logic bar_mem;
    logic [AW-1:0] bar_len, bar_addr;
    logic cmd_we, bar_we, irq_we, busy, done;
    logic [AW-1:0] bar_wdata;
    logic [7:0] irq_wdata;
    logic [15:0] used_irqs;
    logic [NDEV-1:0] dev_err;

    logic [15:0]   t_id   [NDEV];
    logic [7:0]    t_irq  [NDEV];
    logic          t_mem  [NDEV*NBAR];
    logic [AW-1:0] t_len  [NDEV*NBAR];
    logic [AW-1:0] t_addr [NDEV*NBAR];

    int checks = 0;
    int fails  = 0;

    int q_kind[$], q_dev[$], q_bar[$], q_val[$];
    int exp_used;
    int exp_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign dev_id   = t_id[tbl_dev];
    assign dev_irq  = t_irq[tbl_dev];
    assign bar_mem  = t_mem[int'(tbl_dev)*NBAR + int'(tbl_bar)];
    assign bar_len  = t_len[int'(tbl_dev)*NBAR + int'(tbl_bar)];
    assign bar_addr = t_addr[int'(tbl_dev)*NBAR + int'(tbl_bar)];

    io_irq_assigner #(.NDEV(NDEV), .NBAR(NBAR), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .irq_mode_adv(irq_mode_adv),
        .tbl_dev(tbl_dev), .tbl_bar(tbl_bar), .dev_id(dev_id), .dev_irq(dev_irq),
        .bar_mem(bar_mem), .bar_len(bar_len), .bar_addr(bar_addr),
        .cmd_we(cmd_we), .bar_we(bar_we), .bar_wdata(bar_wdata),
        .irq_we(irq_we), .irq_wdata(irq_wdata), .busy(busy), .done(done),
        .used_irqs(used_irqs), .dev_err(dev_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_table();
        for (int i = 0; i < NDEV; i++) begin
            t_id[i] = 16'h0; t_irq[i] = 8'hFF;
        end
        for (int i = 0; i < NDEV*NBAR; i++) begin
            t_mem[i] = 1'b0; t_len[i] = '0; t_addr[i] = '0;
        end
    endtask

    task automatic set_bar(input int d, input int b, input bit m, input int len, input int adr);
        t_mem[d*NBAR+b] = m; t_len[d*NBAR+b] = len; t_addr[d*NBAR+b] = adr;
    endtask

    function automatic bit in_pool(input int v);
        return v == 5 || v == 7 || v == 9 || v == 10 || v == 11;
    endfunction

    task automatic build_model(input bit adv);
        longint ptr;
        int cnt;
        q_kind.delete(); q_dev.delete(); q_bar.delete(); q_val.delete();
        ptr = 64'h1000; cnt = 0; exp_used = 0; exp_err = 0;
        for (int d = 0; d < NDEV; d++) begin
            q_kind.push_back(1); q_dev.push_back(d); q_bar.push_back(0); q_val.push_back(0);
            for (int b = 0; b < NBAR; b++) begin
                longint len;
                len = longint'(t_len[d*NBAR+b]);
                if (len == 0 || t_addr[d*NBAR+b] != 0) begin
                end else if (t_mem[d*NBAR+b]) begin
                    exp_err |= (1 << d);
                end else if (ptr + len >= 64'h10000) begin
                    exp_err |= (1 << d);
                end else begin
                    q_kind.push_back(2); q_dev.push_back(d); q_bar.push_back(b);
                    q_val.push_back(int'(ptr));
                    ptr += len;
                end
            end
            if (t_irq[d] == 8'd0) begin
                int v;
                if (adv) begin
                    v = 16 + ((int'(t_id[d]) >> 11) % 4);
                end else begin
                    do cnt = (cnt + 1) % 16; while (!in_pool(cnt));
                    v = cnt;
                    exp_used |= (1 << cnt);
                end
                q_kind.push_back(3); q_dev.push_back(d); q_bar.push_back(0); q_val.push_back(v);
            end
        end
    endtask

    task automatic run_walk(input bit adv, input bit poke_start, input string tag);
        irq_mode_adv = adv;
        build_model(adv);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 1; cyc <= WALK + 1; cyc++) begin
            int kind;
            kind = cmd_we ? 1 : bar_we ? 2 : irq_we ? 3 : 0;
            // R1: busy during walk, done on the cycle after it
            check(busy == (cyc <= WALK) && done == (cyc == WALK + 1), "R1",
                  {30'd0, busy, done}, (cyc <= WALK) ? 2 : 1);
            if (kind != 0) begin
                if (q_kind.size() == 0) begin
                    check(1'b0, "R2 extra write", kind, 0);
                end else begin
                    int ek, ed, eb, ev, av;
                    ek = q_kind.pop_front(); ed = q_dev.pop_front();
                    eb = q_bar.pop_front(); ev = q_val.pop_front();
                    av = (kind == 2) ? int'(bar_wdata) : (kind == 3) ? int'(irq_wdata) : 0;
                    // R2 order, R5/R6 base, R7/R8/R9 numbers
                    check(kind == ek && int'(tbl_dev) == ed, {tag, " R2 write order"},
                          kind*256 + int'(tbl_dev), ek*256 + ed);
                    if (kind == 2) check(int'(tbl_bar) == eb && av == ev,
                                         {tag, " R5 R6 base"}, av, ev);
                    if (kind == 3) check(av == ev, adv ? {tag, " R8 number"} : {tag, " R9 number"},
                                         av, ev);
                end
            end
            if (poke_start && cyc == 5) start = 1'b1;
            if (poke_start && cyc == 6) start = 1'b0;
            @(negedge clk);
        end
        check(q_kind.size() == 0, {tag, " R7 missing writes"}, q_kind.size(), 0);
        check(int'(used_irqs) == exp_used, {tag, " R9 used mask"}, used_irqs, exp_used);
        check(int'(dev_err) == exp_err, {tag, " R4 R6 errors"}, dev_err, exp_err);
        repeat (3) @(negedge clk);
        // R1: idle afterwards, R9 results held
        check(!busy && !done && !cmd_we && !bar_we && !irq_we, {tag, " R1 idle"},
              {28'd0, busy, done, bar_we, irq_we}, 0);
        check(int'(used_irqs) == exp_used && int'(dev_err) == exp_err, {tag, " R9 held"},
              used_irqs, exp_used);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        clear_table();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && used_irqs == 0 && dev_err == 0 && !cmd_we && !bar_we && !irq_we,
              "R1 reset", {busy, done, used_irqs}, 0);

        // Run A: legacy, skip/mem/overflow mix, 0xFF and nonzero untouched (R3 R4 R6 R7)
        set_bar(0, 0, 0, 'h100, 0);
        set_bar(1, 0, 1, 'h1000, 0);
        set_bar(1, 1, 0, 'h10, 'h2000);
        set_bar(2, 0, 0, 'hF000, 0);
        set_bar(2, 1, 0, 'h20, 0);
        set_bar(3, 0, 0, 'h8, 0);
        set_bar(3, 1, 1, 'h1000, 'hF0000);
        set_bar(4, 0, 0, 'h40, 0);
        set_bar(5, 1, 0, 'h4, 0);
        t_irq[0] = 0; t_irq[1] = 8'hFF; t_irq[2] = 0; t_irq[3] = 3; t_irq[4] = 0; t_irq[5] = 0;
        run_walk(1'b0, 1'b0, "runA");

        // Run B: legacy, six requests -> wrap to 5, counter cleared, start in mid-walk ignored (R9 R1)
        for (int i = 0; i < NDEV; i++) t_irq[i] = 0;
        run_walk(1'b0, 1'b1, "runB");

        // Run C: advanced mapping and exact window edge (R8 R6)
        clear_table();
        set_bar(0, 0, 0, 'hF000, 0);
        set_bar(0, 1, 0, 'hEFFF, 0);
        set_bar(1, 0, 0, 'h1, 0);
        t_id[0] = 16'h1800; t_id[1] = 16'h2000; t_id[2] = 16'h4800;
        t_id[3] = 16'hF800; t_id[4] = 16'h5000; t_id[5] = 16'h0000;
        t_irq[0] = 0; t_irq[1] = 0; t_irq[2] = 8'hFF; t_irq[3] = 0; t_irq[4] = 0; t_irq[5] = 9;
        run_walk(1'b1, 1'b0, "runC");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule